// File: doc/BRIEF.md
# Nibble-Wide DRAM Controller with Three-Way Arbiter

This block lets three byte-oriented clients share one external DRAM that has a 4-bit data bus. The three clients are an I/O DMA writer, an image-load DMA reader and a processor port. Each client raises a request with a byte address, a write flag and write data. It holds the request until it sees a one-cycle acknowledge. The block picks one client at a time and opens the row. It then moves the byte as two nibbles in one fast-page-mode cycle, with two column strobes inside one row strobe. On a read, it returns the byte joined from the two nibbles.

The arbiter uses a fixed priority order. It also caps how many grants in a row one client can take while another client waits, so no client can hold the memory forever. A free-running interval counter starts column-before-row refresh cycles. A refresh goes ahead of every waiting client and waits only for an access that is already under way. A configuration input selects the smaller or the larger device geometry. This sets how many row and column bits the byte address uses.

Top module: `nib_dram_arb`

## Requirements
- R1: While reset is asserted, dramRasN, dramCasN and dramWeN are 1, dramDqOe is 0, and gntVec and ackVec are all zero.
- R2: A write moves the byte in one row-strobe-low period with two column-strobe-low periods. Bits 7:4 go at the even column address (address bit 0 = 0) and bits 3:0 go at the following odd column address, with dramWeN low.
- R3: A read returns on rdData the nibble read at the even column in bits 7:4 and the nibble read at the odd column in bits 3:0. rdData is valid in the cycle ackVec is high.
- R4: The nibble address is {byte address, nibble select}, where select is 0 for the high nibble and 1 for the low nibble. With sizeSel=0, the column is nibble address bits 8:0 and the row is bits 17:9, and dramAddr bit 9 is 0. With sizeSel=1, the column is bits 9:0 and the row is bits 19:10.
- R5: A grant bit rises in the row-strobe cycle. The matching acknowledge is a single-cycle pulse exactly four cycles later, and the grant drops after it.
- R6: Requests are served in fixed priority: index 0 (I/O DMA) first, then index 1 (image load), then index 2 (processor).
- R7: After 4 grants in a row to one client, if another client is waiting, the next grant goes to the first waiting client found by a rotation search. The search starts at a rotation pointer, skips the capped client, and moves the pointer to the slot after the chosen client. The pointer is 0 after reset.
- R8: Every REF_PERIOD cycles, a refresh is marked pending. At the next idle point it runs before any request: dramCasN falls while dramRasN is high, and then dramRasN falls.
- R9: At most one grant bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sizeSel | input | 1 | Geometry select: 0 = small, 1 = large |
| reqVec | input | NREQ | Request per client |
| wrVec | input | NREQ | Write flag per client |
| addrVec | input | NREQ x ADDR_W | Byte address per client |
| wdataVec | input | NREQ x 8 | Write byte per client |
| gntVec | output | NREQ | Client currently owns the DRAM |
| ackVec | output | NREQ | One-cycle completion pulse |
| rdData | output | 8 | Read byte, valid with ack |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramAddr | output | LG_BITS | Multiplexed row/column address |
| dramDqOut | output | 4 | Nibble driven on writes |
| dramDqOe | output | 1 | Drive enable for dramDqOut |
| dramDqIn | input | 4 | Nibble returned by the DRAM |

## Verification
Each fault in the internal state shows up at the ports within one access:
- A wrong column-select phase swaps the nibbles. This shows as a byte mismatch on the read that follows, or as the wrong column parity at the second column strobe.
- A stuck streak counter or rotation pointer shows within the first ten acknowledges of a saturated load, because the order of served clients departs from the fixed 0,0,0,0,1,0,0,0,0,2 pattern.
- A broken refresh counter or a refresh that loses to requests shows as a wrong count of column-before-row events over a 300-cycle window, under both idle and full load.

// File: rtl/nda_pkg.sv
package nda_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RAS, ST_CAS0, ST_GAP, ST_CAS1, ST_PRE,
    ST_RCAS, ST_RRAS, ST_RHOLD, ST_REND
  } phase_t;

  typedef struct packed {
    logic latch;   // capture selected client's address and data
    logic selCol;  // present column instead of row
    logic oddCol;  // low-nibble column
    logic capHi;   // sample first nibble
    logic capLo;   // sample second nibble, form byte
    logic drive;   // drive write nibble
  } strobe_t;

endpackage

// File: rtl/nda_ctrl.sv
module nda_ctrl
  import nda_pkg::*;
#(
  parameter int NREQ       = 3,
  parameter int MAX_RUN    = 4,
  parameter int REF_PERIOD = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NREQ-1:0]         reqVec,
  input  logic [NREQ-1:0]         wrVec,
  output logic [NREQ-1:0]         gntVec,
  output logic [NREQ-1:0]         ackVec,
  output logic                    dramRasN,
  output logic                    dramCasN,
  output logic                    dramWeN,
  output strobe_t                 stb,
  output logic [$clog2(NREQ)-1:0] selIdx
);
  localparam int IDX_W = $clog2(NREQ);
  localparam int RUN_W = $clog2(MAX_RUN + 1);
  localparam int REF_W = $clog2(REF_PERIOD);

  phase_t             state;
  logic [IDX_W-1:0]   owner, rrPtr, prioIdx, rotIdx, pickIdx;
  logic [RUN_W-1:0]   streak;
  logic [REF_W-1:0]   refCnt;
  logic               refPend, curWrite, rotFound, capped, startAcc;

  // Arbitration: fixed priority, overridden by rotation once the run cap is hit
  always_comb begin
    prioIdx  = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (reqVec[i]) prioIdx = IDX_W'(i);
    rotIdx   = '0;
    rotFound = 1'b0;
    for (int k = 0; k < NREQ; k++) begin
      int c;
      c = int'(rrPtr) + k;
      if (c >= NREQ) c = c - NREQ;
      if (!rotFound && reqVec[c] && c != int'(owner)) begin
        rotIdx   = IDX_W'(c);
        rotFound = 1'b1;
      end
    end
    capped  = (streak == RUN_W'(MAX_RUN)) && reqVec[owner] && rotFound;
    pickIdx = capped ? rotIdx : prioIdx;
  end

  assign startAcc = (state == ST_IDLE) && !refPend && (|reqVec);
  assign selIdx   = pickIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      owner    <= '0;
      rrPtr    <= '0;
      streak   <= '0;
      refCnt   <= '0;
      refPend  <= 1'b0;
      curWrite <= 1'b0;
    end else begin
      if (refCnt == REF_W'(REF_PERIOD - 1)) begin
        refCnt  <= '0;
        refPend <= 1'b1;
      end else begin
        refCnt <= refCnt + 1'b1;
        if (state == ST_IDLE && refPend) refPend <= 1'b0;
      end
      unique case (state)
        ST_IDLE: begin
          if (refPend) state <= ST_RCAS;
          else if (startAcc) begin
            state    <= ST_RAS;
            owner    <= pickIdx;
            curWrite <= wrVec[pickIdx];
            if (pickIdx == owner && streak != '0)
              streak <= (streak == RUN_W'(MAX_RUN)) ? streak : streak + 1'b1;
            else
              streak <= RUN_W'(1);
            if (capped)
              rrPtr <= (rotIdx == IDX_W'(NREQ - 1)) ? '0 : rotIdx + 1'b1;
          end
        end
        ST_RAS:   state <= ST_CAS0;
        ST_CAS0:  state <= ST_GAP;
        ST_GAP:   state <= ST_CAS1;
        ST_CAS1:  state <= ST_PRE;
        ST_PRE:   state <= ST_IDLE;
        ST_RCAS:  state <= ST_RRAS;
        ST_RRAS:  state <= ST_RHOLD;
        ST_RHOLD: state <= ST_REND;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  logic inAcc;
  assign inAcc    = (state == ST_RAS) || (state == ST_CAS0) || (state == ST_GAP)
                 || (state == ST_CAS1) || (state == ST_PRE);
  assign dramRasN = !((inAcc && state != ST_PRE) || state == ST_RRAS || state == ST_RHOLD);
  assign dramCasN = !(state == ST_CAS0 || state == ST_CAS1 || state == ST_RCAS
                   || state == ST_RRAS);
  assign dramWeN  = !(curWrite && (state == ST_CAS0 || state == ST_CAS1));

  always_comb begin
    gntVec = '0;
    ackVec = '0;
    if (inAcc) gntVec[owner] = 1'b1;
    if (state == ST_PRE) ackVec[owner] = 1'b1;
  end

  assign stb.latch  = startAcc;
  assign stb.selCol = (state == ST_CAS0) || (state == ST_GAP) || (state == ST_CAS1);
  assign stb.oddCol = (state == ST_GAP) || (state == ST_CAS1);
  assign stb.capHi  = (state == ST_CAS0);
  assign stb.capLo  = (state == ST_CAS1);
  assign stb.drive  = curWrite && stb.selCol;

  // Checker state: cycles a pending refresh has waited
  logic [3:0] refWait;
  always_ff @(posedge clk) begin
    if (!rstN || !refPend) refWait <= '0;
    else if (refWait != 4'hF) refWait <= refWait + 1'b1;
  end

  p_gnt_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntVec));
  p_ack_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|gntVec) |-> ##4 (|ackVec));
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|ackVec) |=> !(|ackVec) && !(|gntVec));
  p_ref_wait_r8: assert property (@(posedge clk) disable iff (!rstN)
    refWait <= 4'd7);
  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramRasN) && dramCasN) |-> ##1 !dramRasN ##1 !dramRasN ##1 !dramRasN);

endmodule

// File: rtl/nda_dpath.sv
module nda_dpath
  import nda_pkg::*;
#(
  parameter int NREQ    = 3,
  parameter int SM_BITS = 9,
  parameter int LG_BITS = 10,
  parameter int ADDR_W  = 2 * LG_BITS - 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  strobe_t                           stb,
  input  logic [$clog2(NREQ)-1:0]           selIdx,
  input  logic                              sizeSel,
  input  logic [NREQ-1:0][ADDR_W-1:0]       addrVec,
  input  logic [NREQ-1:0][7:0]              wdataVec,
  input  logic [3:0]                        dramDqIn,
  output logic [LG_BITS-1:0]                dramAddr,
  output logic [3:0]                        dramDqOut,
  output logic                              dramDqOe,
  output logic [7:0]                        rdData
);
  localparam int NIB_W = ADDR_W + 1;

  logic [ADDR_W-1:0] curAddr;
  logic [7:0]        curData;
  logic [3:0]        rdHi;
  logic [NIB_W-1:0]  nibAddr;
  logic [LG_BITS-1:0] rowLg, colLg, rowSm, colSm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curData <= '0;
      rdHi    <= '0;
      rdData  <= '0;
    end else begin
      if (stb.latch) begin
        curAddr <= addrVec[selIdx];
        curData <= wdataVec[selIdx];
      end
      if (stb.capHi) rdHi   <= dramDqIn;
      if (stb.capLo) rdData <= {rdHi, dramDqIn};
    end
  end

  assign nibAddr = {curAddr, stb.oddCol};
  assign rowLg   = nibAddr[2*LG_BITS-1:LG_BITS];
  assign colLg   = nibAddr[LG_BITS-1:0];
  assign rowSm   = LG_BITS'(nibAddr[2*SM_BITS-1:SM_BITS]);
  assign colSm   = LG_BITS'(nibAddr[SM_BITS-1:0]);

  always_comb begin
    if (stb.selCol) dramAddr = sizeSel ? colLg : colSm;
    else            dramAddr = sizeSel ? rowLg : rowSm;
  end

  assign dramDqOut = stb.oddCol ? curData[3:0] : curData[7:4];
  assign dramDqOe  = stb.drive;

  p_even_col_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.capHi |-> !dramAddr[0]);
  p_odd_col_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.capLo |-> dramAddr[0]);
  p_small_msb_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sizeSel |-> !dramAddr[LG_BITS-1]);

endmodule

// File: rtl/nib_dram_arb.sv
module nib_dram_arb
  import nda_pkg::*;
#(
  parameter int NREQ       = 3,
  parameter int SM_BITS    = 9,
  parameter int LG_BITS    = 10,
  parameter int ADDR_W     = 2 * LG_BITS - 1,
  parameter int MAX_RUN    = 4,
  parameter int REF_PERIOD = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sizeSel,
  input  logic [NREQ-1:0]             reqVec,
  input  logic [NREQ-1:0]             wrVec,
  input  logic [NREQ-1:0][ADDR_W-1:0] addrVec,
  input  logic [NREQ-1:0][7:0]        wdataVec,
  output logic [NREQ-1:0]             gntVec,
  output logic [NREQ-1:0]             ackVec,
  output logic [7:0]                  rdData,
  output logic                        dramRasN,
  output logic                        dramCasN,
  output logic                        dramWeN,
  output logic [LG_BITS-1:0]          dramAddr,
  output logic [3:0]                  dramDqOut,
  output logic                        dramDqOe,
  input  logic [3:0]                  dramDqIn
);
  strobe_t                 stb;
  logic [$clog2(NREQ)-1:0] selIdx;

  nda_ctrl #(.NREQ(NREQ), .MAX_RUN(MAX_RUN), .REF_PERIOD(REF_PERIOD)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .wrVec(wrVec),
    .gntVec(gntVec), .ackVec(ackVec), .dramRasN(dramRasN), .dramCasN(dramCasN),
    .dramWeN(dramWeN), .stb(stb), .selIdx(selIdx)
  );

  nda_dpath #(.NREQ(NREQ), .SM_BITS(SM_BITS), .LG_BITS(LG_BITS), .ADDR_W(ADDR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .selIdx(selIdx), .sizeSel(sizeSel),
    .addrVec(addrVec), .wdataVec(wdataVec), .dramDqIn(dramDqIn),
    .dramAddr(dramAddr), .dramDqOut(dramDqOut), .dramDqOe(dramDqOe), .rdData(rdData)
  );

endmodule

// File: tb/test_nib_dram_arb.sv
`timescale 1ns/1ps
module test_nib_dram_arb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic             sizeSel = 1'b0;
  logic [2:0]       reqB = '0, weB = '0;
  logic [2:0][18:0] addrB = '0;
  logic [2:0][7:0]  wdB = '0;
  logic [2:0]       gntVec, ackVec;
  logic [7:0]       rdData;
  logic             rasN, casN, weN, dqOe;
  logic [9:0]       dAddr;
  logic [3:0]       dqOut, dqIn;

  nib_dram_arb i_nib_dram_arb (
    .clk(clk), .rstN(rstN), .sizeSel(sizeSel), .reqVec(reqB), .wrVec(weB),
    .addrVec(addrB), .wdataVec(wdB), .gntVec(gntVec), .ackVec(ackVec),
    .rdData(rdData), .dramRasN(rasN), .dramCasN(casN), .dramWeN(weN),
    .dramAddr(dAddr), .dramDqOut(dqOut), .dramDqOe(dqOe), .dramDqIn(dqIn)
  );

  // Behavioural DRAM model
  logic [3:0] memArr [4096];
  logic [9:0] mRow = '0, rowSeen = '0;
  logic [9:0] colSeen [2];
  logic [3:0] nibSeen [2];
  logic       prevRas = 1'b1, prevCas = 1'b1;
  int         casIdx = 0, refCount = 0;

  assign dqIn = (!rasN && !casN && weN) ? memArr[{mRow[5:0], dAddr[5:0]}] : 4'h0;

  always @(posedge clk) begin
    if (prevRas && !rasN && casN) begin
      mRow = dAddr; rowSeen = dAddr; casIdx = 0;
    end
    if (prevRas && !rasN && !casN) refCount = refCount + 1;
    if (!rasN && prevCas && !casN && casIdx < 2) begin
      colSeen[casIdx] = dAddr;
      if (!weN) begin
        nibSeen[casIdx] = dqOut;
        memArr[{mRow[5:0], dAddr[5:0]}] = dqOut;
      end
      casIdx = casIdx + 1;
    end
    prevRas = rasN;
    prevCas = casN;
  end

  // Port monitor
  int   cyc = 0, gRise = 0, lastLat = 0, logN = 0, ackRun = 0, maxAckRun = 0;
  logic prevGnt = 1'b0;
  logic [1:0] ackLog [16];
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (|gntVec && !prevGnt) gRise = cyc;
    prevGnt = |gntVec;
    if (|ackVec) begin
      lastLat = cyc - gRise;
      ackRun = ackRun + 1;
      if (ackRun > maxAckRun) maxAckRun = ackRun;
      for (int i = 0; i < 3; i++)
        if (ackVec[i] && logN < 16) ackLog[logN] = 2'(i);
      logN = logN + 1;
    end else ackRun = 0;
  end

  int nChk = 0, nFail = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] expRow(input logic m, input logic [18:0] a);
    logic [19:0] n;
    n = {a, 1'b0};
    return m ? n[19:10] : {1'b0, n[17:9]};
  endfunction
  function automatic logic [9:0] expCol(input logic m, input logic [18:0] a, input logic odd);
    logic [19:0] n;
    n = {a, odd};
    return m ? n[9:0] : {1'b0, n[8:0]};
  endfunction

  task automatic doReset();
    rstN = 1'b0; reqB = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic access(input int who, input logic wr, input logic [18:0] a,
                        input logic [7:0] d, output logic [7:0] rd);
    int guard;
    @(negedge clk);
    addrB[who] = a; wdB[who] = d; weB[who] = wr; reqB[who] = 1'b1;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!ackVec[who] && guard < 100);
    rd = rdData;
    reqB[who] = 1'b0;
    if (guard >= 100) chk("R5 ack timeout", 1, 0);
  endtask

  typedef struct packed {
    logic [1:0]  who;
    logic        mode;
    logic [18:0] addr;
    logic [7:0]  dat;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 19'h00123, 8'hA5},
    '{2'd1, 1'b0, 19'h1FFFF, 8'h3C},
    '{2'd2, 1'b1, 19'h7FFFF, 8'h96},
    '{2'd0, 1'b1, 19'h2AAAA, 8'h5F},
    '{2'd1, 1'b0, 19'h40155, 8'hE1},
    '{2'd2, 1'b1, 19'h00200, 8'h0F}
  };

  initial begin
    logic [7:0] rd;
    logic [1:0] expA [10];
    logic [1:0] expB [6];
    expA = '{2'd0,2'd0,2'd0,2'd0,2'd1,2'd0,2'd0,2'd0,2'd0,2'd2};
    expB = '{2'd1,2'd1,2'd1,2'd1,2'd2,2'd1};

    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 rasN", rasN, 1);
    chk("R1 casN", casN, 1);
    chk("R1 weN", weN, 1);
    chk("R1 dqOe", dqOe, 0);
    chk("R1 gnt/ack", {gntVec, ackVec}, 0);
    doReset();

    // Vector table: write, check page-mode cycle, read back
    for (int v = 0; v < 6; v++) begin
      sizeSel = VECS[v].mode;
      access(int'(VECS[v].who), 1'b1, VECS[v].addr, VECS[v].dat, rd);
      chk("R4 row", rowSeen, expRow(VECS[v].mode, VECS[v].addr));
      chk("R2 even col", colSeen[0], expCol(VECS[v].mode, VECS[v].addr, 1'b0));
      chk("R2 odd col", colSeen[1], expCol(VECS[v].mode, VECS[v].addr, 1'b1));
      chk("R2 high nibble first", nibSeen[0], VECS[v].dat[7:4]);
      chk("R2 low nibble second", nibSeen[1], VECS[v].dat[3:0]);
      access(int'(VECS[v].who), 1'b0, VECS[v].addr, 8'h00, rd);
      chk("R3 read byte", rd, VECS[v].dat);
      chk("R5 gnt-to-ack latency", lastLat, 4);
    end
    chk("R5 ack width", maxAckRun, 1);

    // R6, R7: all three saturated
    doReset();
    weB = '0; logN = 0;
    @(negedge clk);
    reqB = 3'b111;
    for (int g = 0; g < 200 && logN < 10; g++) @(negedge clk);
    reqB = '0;
    chk("R6 first grant to index 0", ackLog[0], 0);
    for (int i = 1; i < 10; i++) chk("R7 order, three waiting", ackLog[i], expA[i]);

    // R6, R7: clients 1 and 2 saturated
    doReset();
    logN = 0;
    @(negedge clk);
    reqB = 3'b110;
    for (int g = 0; g < 200 && logN < 6; g++) @(negedge clk);
    reqB = '0;
    chk("R6 index 1 over 2", ackLog[0], 1);
    for (int i = 1; i < 6; i++) chk("R7 order, two waiting", ackLog[i], expB[i]);

    // R8: refresh while idle
    doReset();
    refCount = 0;
    repeat (300) @(negedge clk);
    chk("R8 idle refresh count in [4,5]", (refCount >= 4 && refCount <= 5), 1);

    // R8: refresh under continuous load from index 0
    doReset();
    refCount = 0; logN = 0;
    reqB = 3'b001;
    repeat (300) @(negedge clk);
    reqB = '0;
    chk("R8 loaded refresh count in [4,5]", (refCount >= 4 && refCount <= 5), 1);
    chk("R8 accesses continue under load", (logN >= 30), 1);

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #1000000;
    nChk++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule